// File: doc/BRIEF.md
# Dual-Plane Busy-Status Read Generator

This block sits on the read path of a two-plane flash array. While an internal program or erase is running, or while an erase is on hold, it replaces a few bits of the word returned to the host with status bits. Software polls these bits to learn when the operation is over. Reads aimed at the plane that is not busy get the stored word unchanged. Software can therefore keep fetching from one plane while the other plane is being written.

The host read strobe `rd_n` is active low. The block counts a read as finished on the clock after `rd_n` rises. That event advances the toggle bits of the plane that was read. The program and erase engines report what they are doing through level inputs: busy flags, the plane each one works on, the word being programmed, and an address inside the sector whose erase is on hold. The block also drives a busy indication meant for an open-drain ready line.

The address space is split at `PLANE_B_BASE`. Below that address is plane 0; at or above it is plane 1. Sectors start with `BOOT_SECTS` small sectors of 2^`SMALL_SHIFT` words from address 0. Above them come sectors of 2^`BIG_SHIFT` words. This sector layout is used only to decide whether a read falls in the sector whose erase is on hold.

Top module: `fsst_status_gen`

## Requirements
- R1: While `prog_busy` is 1, a read of plane `prog_plane` returns bit 7 as the inverse of `prog_data[7]`. Once `prog_busy` is 0, that plane returns `arr_data` (unless R2 or R4 applies).
- R2: While `erase_busy` is 1 and no program is running in the same plane, a read of plane `erase_plane` returns bit 7 = 0.
- R3: On reads of a plane that has a program or erase running, bit 6 starts at 0 and inverts after each completed read of that plane. A completed read is a clock edge at which `rd_n` is 1 after having been 0. The count returns to 0 on the first clock edge at which the plane has no operation running.
- R4: While `susp_active` is 1, with no program or erase running in the plane read, a read of the same sector as `susp_addr` returns bit 7 = 1, bit 6 = 1 and bit 2 = parity. The parity starts at 0 and inverts after each completed read of that sector. It returns to 0 on the first clock edge at which `susp_active` is 0.
- R5: While `susp_active` is 1, a read of any other sector in a plane with no running operation returns `arr_data`. Sector numbers count the small boot sectors first, then the large ones.
- R6: A read of a plane with no program or erase running and no suspended sector hit returns `arr_data`. An address at or above `PLANE_B_BASE` is in plane 1.
- R7: `rb_low` is 1 on the clock after any cycle in which `prog_busy` or `erase_busy` is 1. It is 0 after any other cycle and after reset.
- R8: All bits other than 7, 6 and 2 always equal `arr_data`.
- R9: During a program in a plane that also holds the suspended sector, a read of that sector returns program status on bits 7 and 6, and the suspend parity of R4 on bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Host read strobe, active low |
| rd_addr | input | AW | Word address of the current read |
| arr_data | input | DW | Word stored in the array at `rd_addr` |
| prog_busy | input | 1 | A program operation is running |
| prog_plane | input | 1 | Plane of the running program |
| prog_data | input | DW | Word being programmed |
| erase_busy | input | 1 | An erase is running (not on hold) |
| erase_plane | input | 1 | Plane of the running erase |
| susp_active | input | 1 | An erase is on hold |
| susp_addr | input | AW | Any address inside the sector whose erase is on hold |
| rd_data | output | DW | Read word with status bits substituted |
| rb_low | output | 1 | 1 pulls the ready line low (busy) |

## Verification
The bench builds the block with a 12-bit address, the plane split at 1024, four boot sectors of 64 words and large sectors of 256 words. With these values a few short reads cover both planes, the small-to-large sector boundary at 256 and neighbouring sectors on either side of a suspended one. At the default sizes these boundaries sit hundreds of kilowords apart. The small sizes also make it possible to suspend in a boot sector and read the next boot sector, and to program in the plane that holds the suspended sector.

// File: rtl/fsst_pkg.sv
package fsst_pkg;

  localparam int unsigned NPLANE   = 2;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned SUSP_BIT = 2;

  typedef struct packed {
    logic prog;
    logic erase;
    logic susp;
  } fsst_hit_t;

  function automatic logic upper_plane(input logic [31:0] addr,
                                       input logic [31:0] split);
    return addr >= split;
  endfunction

  function automatic logic [31:0] sector_index(input logic [31:0] addr,
                                               input int unsigned boot_sects,
                                               input int unsigned small_shift,
                                               input int unsigned big_shift);
    logic [31:0] boot_end;
    boot_end = 32'(boot_sects) << small_shift;
    if (addr < boot_end) return addr >> small_shift;
    return 32'(boot_sects) + ((addr - boot_end) >> big_shift);
  endfunction

endpackage

// File: rtl/fsst_decode.sv
module fsst_decode
  import fsst_pkg::*;
#(
  parameter int unsigned AW           = 20,
  parameter int unsigned PLANE_B_BASE = 32'h40000,
  parameter int unsigned BOOT_SECTS   = 8,
  parameter int unsigned SMALL_SHIFT  = 12,
  parameter int unsigned BIG_SHIFT    = 15
) (
  input  logic              [AW-1:0] rd_addr,
  input  logic                       prog_busy,
  input  logic                       prog_plane,
  input  logic                       erase_busy,
  input  logic                       erase_plane,
  input  logic                       susp_active,
  input  logic              [AW-1:0] susp_addr,
  output logic                       rd_plane,
  output fsst_hit_t                  hit,
  output logic          [NPLANE-1:0] plane_busy
);

  logic [31:0] rd_wide;
  logic [31:0] susp_wide;
  logic [31:0] rd_sector;
  logic [31:0] susp_sector;

  assign rd_wide     = 32'(rd_addr);
  assign susp_wide   = 32'(susp_addr);
  assign rd_plane    = upper_plane(rd_wide, 32'(PLANE_B_BASE));
  assign rd_sector   = sector_index(rd_wide, BOOT_SECTS, SMALL_SHIFT, BIG_SHIFT);
  assign susp_sector = sector_index(susp_wide, BOOT_SECTS, SMALL_SHIFT, BIG_SHIFT);

  assign hit.prog  = prog_busy && (prog_plane == rd_plane);
  assign hit.erase = erase_busy && (erase_plane == rd_plane);
  assign hit.susp  = susp_active && (rd_sector == susp_sector);

  for (genvar p = 0; p < NPLANE; p++) begin : g_busy
    assign plane_busy[p] = (prog_busy && (prog_plane == 1'(p))) ||
                           (erase_busy && (erase_plane == 1'(p)));
  end

endmodule

// File: rtl/fsst_toggle.sv
module fsst_toggle
  import fsst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              rd_plane,
  input  fsst_hit_t         hit,
  input  logic [NPLANE-1:0] plane_busy,
  input  logic              susp_active,
  output logic [NPLANE-1:0] t6,
  output logic              t2,
  output logic              rd_end
);

  logic rd_n_q;
  logic t2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_n_q <= 1'b1;
    else        rd_n_q <= rd_n;
  end

  assign rd_end = rd_n && !rd_n_q;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    logic q;
    logic flip;
    assign flip = rd_end && (hit.prog || hit.erase) && (rd_plane == 1'(p));

    always_ff @(posedge clk) begin
      if (!rst_n)              q <= 1'b0;
      else if (!plane_busy[p]) q <= 1'b0;
      else if (flip)           q <= ~q;
    end
    assign t6[p] = q;

    // R3: toggle state returns to 0 once the plane is idle
    a_r3_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !plane_busy[p] |=> !t6[p]);
    // R3: a completed read of a busy plane inverts its toggle
    a_r3_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (plane_busy[p] && flip) |=> (t6[p] != $past(t6[p])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            t2_q <= 1'b0;
    else if (!susp_active) t2_q <= 1'b0;
    else if (rd_end && hit.susp) t2_q <= ~t2_q;
  end
  assign t2 = t2_q;

  // R4: suspend parity advances on each completed read of the held sector
  a_r4_susp_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_active && rd_end && hit.susp) |=> (t2 != $past(t2)));
  // R4: suspend parity is cleared when the hold ends
  a_r4_susp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !susp_active |=> !t2);

endmodule

// File: rtl/fsst_merge.sv
module fsst_merge
  import fsst_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] arr_data,
  input  logic [DW-1:0] prog_data,
  input  fsst_hit_t     hit,
  input  logic          t6_sel,
  input  logic          t2,
  output logic [DW-1:0] rd_data
);

  always_comb begin
    rd_data = arr_data;
    if (hit.prog) begin
      rd_data[POLL_BIT] = ~prog_data[POLL_BIT];
      rd_data[TOG_BIT]  = t6_sel;
      if (hit.susp) rd_data[SUSP_BIT] = t2;
    end else if (hit.erase) begin
      rd_data[POLL_BIT] = 1'b0;
      rd_data[TOG_BIT]  = t6_sel;
    end else if (hit.susp) begin
      rd_data[POLL_BIT] = 1'b1;
      rd_data[TOG_BIT]  = 1'b1;
      rd_data[SUSP_BIT] = t2;
    end
  end

endmodule

// File: rtl/fsst_status_gen.sv
module fsst_status_gen
  import fsst_pkg::*;
#(
  parameter int unsigned AW           = 20,
  parameter int unsigned DW           = 16,
  parameter int unsigned PLANE_B_BASE = 32'h40000,
  parameter int unsigned BOOT_SECTS   = 8,
  parameter int unsigned SMALL_SHIFT  = 12,
  parameter int unsigned BIG_SHIFT    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          prog_busy,
  input  logic          prog_plane,
  input  logic [DW-1:0] prog_data,
  input  logic          erase_busy,
  input  logic          erase_plane,
  input  logic          susp_active,
  input  logic [AW-1:0] susp_addr,
  output logic [DW-1:0] rd_data,
  output logic          rb_low
);

  localparam logic [DW-1:0] STATUS_MASK =
    (DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT) | (DW'(1) << SUSP_BIT);

  logic              rd_plane;
  fsst_hit_t         hit;
  logic [NPLANE-1:0] plane_busy;
  logic [NPLANE-1:0] t6;
  logic              t2;
  logic              rd_end;
  logic              t6_sel;
  logic              any_busy;
  logic              rb_q;

  fsst_decode #(
    .AW(AW), .PLANE_B_BASE(PLANE_B_BASE), .BOOT_SECTS(BOOT_SECTS),
    .SMALL_SHIFT(SMALL_SHIFT), .BIG_SHIFT(BIG_SHIFT)
  ) u_decode (
    .rd_addr(rd_addr), .prog_busy(prog_busy), .prog_plane(prog_plane),
    .erase_busy(erase_busy), .erase_plane(erase_plane),
    .susp_active(susp_active), .susp_addr(susp_addr),
    .rd_plane(rd_plane), .hit(hit), .plane_busy(plane_busy)
  );

  fsst_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_plane(rd_plane), .hit(hit),
    .plane_busy(plane_busy), .susp_active(susp_active),
    .t6(t6), .t2(t2), .rd_end(rd_end)
  );

  assign t6_sel = t6[rd_plane];

  fsst_merge #(.DW(DW)) u_merge (
    .arr_data(arr_data), .prog_data(prog_data), .hit(hit),
    .t6_sel(t6_sel), .t2(t2), .rd_data(rd_data)
  );

  assign any_busy = prog_busy || erase_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) rb_q <= 1'b0;
    else        rb_q <= any_busy;
  end
  assign rb_low = rb_q;

  a_r1_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    hit.prog |-> (rd_data[POLL_BIT] == ~prog_data[POLL_BIT]));
  a_r2_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.erase && !hit.prog) |-> !rd_data[POLL_BIT]);
  a_r4_held_sector: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.susp && !hit.prog && !hit.erase) |-> (rd_data[POLL_BIT] && rd_data[TOG_BIT]));
  a_r6_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit.prog || hit.erase || hit.susp) |-> (rd_data == arr_data));
  a_r8_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & ~STATUS_MASK) == (arr_data & ~STATUS_MASK)));
  a_r7_busy_pull: assert property (@(posedge clk) disable iff (!rst_n)
    any_busy |=> rb_low);
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !any_busy |=> !rb_low);

endmodule

// File: tb/fsst_status_gen_tb.sv
module fsst_status_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int PB = 1024;
  localparam int NBOOT = 4;
  localparam int SMALL_WORDS = 64;
  localparam int BIG_WORDS = 256;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] arr_data = '0;
  logic          prog_busy = 1'b0;
  logic          prog_plane = 1'b0;
  logic [DW-1:0] prog_data = '0;
  logic          erase_busy = 1'b0;
  logic          erase_plane = 1'b0;
  logic          susp_active = 1'b0;
  logic [AW-1:0] susp_addr = '0;
  logic [DW-1:0] rd_data;
  logic          rb_low;

  fsst_status_gen #(
    .AW(AW), .DW(DW), .PLANE_B_BASE(PB), .BOOT_SECTS(NBOOT),
    .SMALL_SHIFT(6), .BIG_SHIFT(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
    .arr_data(arr_data), .prog_busy(prog_busy), .prog_plane(prog_plane),
    .prog_data(prog_data), .erase_busy(erase_busy), .erase_plane(erase_plane),
    .susp_active(susp_active), .susp_addr(susp_addr),
    .rd_data(rd_data), .rb_low(rb_low)
  );

  int vectors = 0;
  int miscomp = 0;
  bit done = 1'b0;

  int  reads_pl [2];
  int  reads_susp;
  bit  exp_rb;
  bit  prev_rd_n;

  function automatic int sect(input int a);
    if (a < NBOOT * SMALL_WORDS) return a / SMALL_WORDS;
    return NBOOT + (a - NBOOT * SMALL_WORDS) / BIG_WORDS;
  endfunction

  function automatic int plane(input int a);
    return (a >= PB) ? 1 : 0;
  endfunction

  // reference bookkeeping of completed reads
  always @(posedge clk) begin
    int  pa;
    bit  ends;
    bit  busy_p;
    if (!rst_n) begin
      reads_pl[0] = 0; reads_pl[1] = 0; reads_susp = 0;
      exp_rb = 1'b0; prev_rd_n = 1'b1;
    end else begin
      pa = plane(int'(rd_addr));
      ends = rd_n && !prev_rd_n;
      for (int p = 0; p < 2; p++) begin
        busy_p = (prog_busy && int'(prog_plane) == p) ||
                 (erase_busy && int'(erase_plane) == p);
        if (!busy_p) reads_pl[p] = 0;
        else if (ends && p == pa) reads_pl[p] = reads_pl[p] + 1;
      end
      if (!susp_active) reads_susp = 0;
      else if (ends && sect(int'(rd_addr)) == sect(int'(susp_addr)))
        reads_susp = reads_susp + 1;
      exp_rb = prog_busy || erase_busy;
      prev_rd_n = rd_n;
    end
  end

  always @(negedge clk) begin
    int pa;
    bit hp, he, hs;
    logic [DW-1:0] exp;
    string tag;
    if (!done) begin
      pa = plane(int'(rd_addr));
      hp = prog_busy && int'(prog_plane) == pa;
      he = erase_busy && int'(erase_plane) == pa;
      hs = susp_active && sect(int'(rd_addr)) == sect(int'(susp_addr));
      exp = arr_data;
      if (hp) begin
        exp[7] = ~prog_data[7];
        exp[6] = reads_pl[pa][0];
        if (hs) exp[2] = reads_susp[0];
      end else if (he) begin
        exp[7] = 1'b0;
        exp[6] = reads_pl[pa][0];
      end else if (hs) begin
        exp[7] = 1'b1;
        exp[6] = 1'b1;
        exp[2] = reads_susp[0];
      end
      vectors++;
      if (rd_data !== exp) begin
        if ((rd_data[5:3] !== exp[5:3]) || (rd_data[1:0] !== exp[1:0]) ||
            (rd_data[15:8] !== exp[15:8])) tag = "R8";
        else if (rd_data[7] !== exp[7]) tag = hp ? "R1" : (he ? "R2" : (hs ? "R4" : "R6"));
        else if (rd_data[6] !== exp[6]) tag = (hp || he) ? "R3" : "R4";
        else if (hs && hp) tag = "R9";
        else if (hs) tag = "R4";
        else tag = susp_active ? "R5" : "R6";
        miscomp++;
        $display("FAIL %s addr=%0d rd_data actual=%h expected=%h", tag, rd_addr, rd_data, exp);
      end
      vectors++;
      if (rb_low !== exp_rb) begin
        miscomp++;
        $display("FAIL R7 rb_low actual=%b expected=%b", rb_low, exp_rb);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] d);
    step();
    rd_addr = AW'(a);
    arr_data = d;
    rd_n = 1'b0;
    step();
    step();
    rd_n = 1'b1;
    step();
    step();
  endtask

  task automatic reads(input int a, input int n);
    for (int i = 0; i < n; i++) do_read(a, DW'($urandom));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      miscomp++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    // reset state: rb_low 0, pass-through (R7, R6)
    repeat (3) step();
    rst_n = 1'b1;
    // R6: idle reads in both planes
    do_read(5, 16'hFFFF);
    do_read(1500, 16'h0000);
    // R1, R3, R8: program in plane 0 with data bit 7 = 1
    prog_plane = 1'b0; prog_data = 16'h00A5; prog_busy = 1'b1;
    reads(300, 4);
    reads(2000, 2);          // R6: other plane untouched
    do_read(300, 16'h5A5A);
    prog_busy = 1'b0;
    reads(300, 2);           // R1: true data after completion
    // R3: second program restarts the toggle at 0, bit 7 = 0 data
    prog_plane = 1'b1; prog_data = 16'h0012; prog_busy = 1'b1;
    reads(3000, 3);
    prog_busy = 1'b0;
    // R2, R3: erase in plane 1
    erase_plane = 1'b1; erase_busy = 1'b1;
    reads(2100, 4);
    reads(700, 2);
    // R4, R5: hold the erase, sector containing 2000
    erase_busy = 1'b0; susp_active = 1'b1; susp_addr = AW'(2000);
    reads(2010, 3);
    reads(2300, 2);          // R5: neighbouring large sector
    reads(1790, 2);          // R5: sector just below
    // R9: program in the plane holding the suspended sector
    prog_plane = 1'b1; prog_data = 16'h0080; prog_busy = 1'b1;
    reads(2010, 3);
    reads(3000, 2);
    prog_busy = 1'b0;
    reads(2010, 2);
    // resume and finish the erase
    susp_active = 1'b0; erase_busy = 1'b1;
    reads(2010, 2);
    erase_busy = 1'b0;
    reads(2010, 1);
    // R4, R5: hold in a small boot sector, probe boot boundaries
    susp_addr = AW'(70); susp_active = 1'b1;
    reads(100, 3);
    reads(130, 2);
    reads(10, 2);
    reads(256, 1);
    susp_active = 1'b0;
    reads(100, 2);
    // R7: busy pulse of a single cycle
    step();
    erase_plane = 1'b0; erase_busy = 1'b1;
    step();
    erase_busy = 1'b0;
    repeat (3) step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule